// File: doc/BRIEF.md
# Interrupt Entry Sequencer with NMI Takeover

This block performs the bus activity a small 8-bit processor core needs to enter a maskable interrupt. When the core raises `irq_req` while the sequencer is idle, the block takes a copy of the program counter, stack pointer and status byte. It then drives a fixed seven-cycle pattern on a synchronous memory port. The pattern is two throw-away reads at the program counter, three stack writes (counter high byte, counter low byte, status), and a two-byte vector read. The new program counter, stack pointer and status are returned on its outputs.

A non-maskable interrupt that is already pending when the status push completes takes over the vector read. The block reads the non-maskable vector instead of the maskable one and pulses `nmi_clear` for one cycle, so the external pending flag drops and the non-maskable entry is not run again. Detecting the non-maskable edge, and decoding the instruction that started the entry, are left to the surrounding core.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_rd`, `mem_wr` and `nmi_clear` are 0, and `pc_out`, `sp_out` and `p_out` are 0.
- R2: `irq_req` sampled high while idle starts a sequence. In cycles 1 and 2 after that edge, `mem_rd`=1, `mem_wr`=0 and `mem_addr` equals the captured program counter.
- R3: Cycle 3 writes the program counter high byte to address 0x0100+SP. Cycle 4 writes the low byte to 0x0100+((SP-1) mod 256). Every stack write has 0x01 as its upper address byte.
- R4: Cycle 5 writes the status byte with bit 4 forced to 0 to 0x0100+((SP-2) mod 256). The final `sp_out` is (SP-3) mod 256, and each write is followed by a one-step decrement.
- R5: After the sequence, `p_out` equals the captured status with bit 2 (interrupt disable) set. Every other bit is unchanged, including bit 4.
- R6: If no NMI is pending at the end of cycle 5, cycles 6 and 7 read 0xFFFE and then 0xFFFF. `pc_out` becomes {data read at 0xFFFF, data read at 0xFFFE}.
- R7: If `nmi_pending` is high at the clock edge that ends cycle 5, cycles 6 and 7 read 0xFFFA and then 0xFFFB. `pc_out` is built from those two bytes.
- R8: `nmi_clear` is high in cycle 6 only when the NMI vector is chosen, and is 0 at all other times. An NMI that becomes pending in cycle 6 or later leaves the IRQ vector in use and is not cleared.
- R9: `done` is high for exactly one cycle, cycle 8, with `pc_out` already holding the new vector. `busy` is high in cycles 1 to 8.
- R10: `irq_req` is ignored while busy, so a held request yields only one sequence. `mem_rd` and `mem_wr` are never high together, and exactly three writes occur per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt entry request |
| nmi_pending | input | 1 | Latched non-maskable interrupt pending flag |
| pc_in | input | 16 | Program counter at entry |
| sp_in | input | 8 | Stack pointer at entry |
| p_in | input | 8 | Status byte at entry |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| nmi_clear | output | 1 | One-cycle pulse that consumes the pending NMI |
| pc_out | output | 16 | Working program counter |
| sp_out | output | 8 | Working stack pointer |
| p_out | output | 8 | Working status byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches, on every cycle, the rules that hold regardless of the input values. These are:
- read and write are exclusive, and stack writes stay in page 0x01;
- every write is followed by a one-step stack pointer decrement, and the third write of a run has bit 4 clear;
- `nmi_clear` appears only together with a read of 0xFFFA;
- `done` is single-cycle, follows a high-byte vector read, and arrives with interrupt-disable set.

What only the bench scenarios can show is the exact per-cycle address and data pattern against arithmetic expectations. The same goes for the hijack window, where pending in cycle 5 redirects the vector read and pending in cycle 6 does not. The bench also shows 8-bit stack wraparound and that a held request starts only one sequence.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes one step per clock; the step order below is the bus order.
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_DUMMY0   = 4'd1,
        ST_DUMMY1   = 4'd2,
        ST_PUSH_HI  = 4'd3,
        ST_PUSH_LO  = 4'd4,
        ST_PUSH_ST  = 4'd5,
        ST_VEC_LO   = 4'd6,
        ST_VEC_HI   = 4'd7,
        ST_DONE     = 4'd8
    } step_t;

    // True for the steps that write to the stack.
    function automatic logic is_push(input step_t s);
        return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_ST);
    endfunction

    // True for the steps that read memory.
    function automatic logic is_read(input step_t s);
        return (s == ST_DUMMY0) || (s == ST_DUMMY1) ||
               (s == ST_VEC_LO) || (s == ST_VEC_HI);
    endfunction

endpackage

// File: rtl/irq_step_fsm.sv
// Step counter for interrupt entry. Starts from idle on a request, walks
// the fixed step order, and samples the NMI pending flag at the edge that
// ends the status push to choose the vector and issue a clear pulse.
// Assumes the pending flag is synchronous to clk.
module irq_step_fsm
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  irq_req,
    input  logic  nmi_pending,
    output step_t state_o,
    output logic  use_nmi_o,
    output logic  nmi_clear_o
);

    step_t state_q, state_d;
    logic  use_nmi_q;
    logic  clr_q;

    // Next-step selection along the fixed order.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = irq_req ? ST_DUMMY0 : ST_IDLE;
            ST_DUMMY0:  state_d = ST_DUMMY1;
            ST_DUMMY1:  state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_PUSH_ST;
            ST_PUSH_ST: state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Vector choice: cleared at start, sampled when the status push ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            use_nmi_q <= 1'b0;
        else if (state_q == ST_IDLE && irq_req)
            use_nmi_q <= 1'b0;
        else if (state_q == ST_PUSH_ST)
            use_nmi_q <= nmi_pending;
    end

    // Clear pulse: high for the low-vector step when the NMI takes over.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= (state_q == ST_PUSH_ST) && nmi_pending;
    end

    assign state_o     = state_q;
    assign use_nmi_o   = use_nmi_q;
    assign nmi_clear_o = clr_q;

endmodule

// File: rtl/irq_ctx_regs.sv
// Working copies of program counter, stack pointer and status. Captured
// at start, decremented after each push, interrupt-disable set after the
// status push, program counter filled from the two vector reads.
// Assumes read data is valid in the same step as its address.
module irq_ctx_regs
    import irq_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDIS_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_t                 state,
    input  logic                  irq_req,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     sp_in,
    input  logic [DATA_W-1:0]     p_in,
    input  logic [DATA_W-1:0]     rdata,
    output logic [2*DATA_W-1:0]   pc_o,
    output logic [DATA_W-1:0]     sp_o,
    output logic [DATA_W-1:0]     p_o
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] p_q;
    logic              start;

    assign start = (state == ST_IDLE) && irq_req;

    // Program counter: capture at start, low then high vector byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (start)
            pc_q <= pc_in;
        else if (state == ST_VEC_LO)
            pc_q[DATA_W-1:0] <= rdata;
        else if (state == ST_VEC_HI)
            pc_q[ADDR_W-1:DATA_W] <= rdata;
    end

    // Stack pointer: capture at start, step down after every push.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (start)
            sp_q <= sp_in;
        else if (is_push(state))
            sp_q <= sp_q - 1'b1;
    end

    // Status: capture at start, mask further interrupts after its push.
    always_ff @(posedge clk) begin
        if (!rst_n)
            p_q <= '0;
        else if (start)
            p_q <= p_in;
        else if (state == ST_PUSH_ST)
            p_q[IDIS_BIT] <= 1'b1;
    end

    assign pc_o = pc_q;
    assign sp_o = sp_q;
    assign p_o  = p_q;

endmodule

// File: rtl/irq_bus_drive.sv
// Combinational bus driver: turns the current step and working registers
// into address, strobes and write data. Pushes address the stack page;
// the status push has the break bit cleared.
module irq_bus_drive
    import irq_seq_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [2*DATA_W-1:0] IRQ_VEC    = 16'hFFFE,
    parameter int                  BRK_BIT    = 4
) (
    input  step_t                 state,
    input  logic                  use_nmi,
    input  logic [2*DATA_W-1:0]   pc,
    input  logic [DATA_W-1:0]     sp,
    input  logic [DATA_W-1:0]     p,
    output logic [2*DATA_W-1:0]   addr,
    output logic                  rd,
    output logic                  wr,
    output logic [DATA_W-1:0]     wdata
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] p_pushed;
    logic [ADDR_W-1:0] vec_lo;

    // Status image with the break bit cleared, bit by bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_pmask
        if (b == BRK_BIT) begin : g_brk
            assign p_pushed[b] = 1'b0;
        end else begin : g_keep
            assign p_pushed[b] = p[b];
        end
    end

    assign vec_lo = use_nmi ? NMI_VEC : IRQ_VEC;

    // Address and data per step.
    always_comb begin
        addr  = '0;
        wdata = '0;
        rd    = is_read(state);
        wr    = is_push(state);
        unique case (state)
            ST_DUMMY0, ST_DUMMY1: addr = pc;
            ST_PUSH_HI: begin
                addr  = {STACK_PAGE, sp};
                wdata = pc[ADDR_W-1:DATA_W];
            end
            ST_PUSH_LO: begin
                addr  = {STACK_PAGE, sp};
                wdata = pc[DATA_W-1:0];
            end
            ST_PUSH_ST: begin
                addr  = {STACK_PAGE, sp};
                wdata = p_pushed;
            end
            ST_VEC_LO: addr = vec_lo;
            ST_VEC_HI: addr = vec_lo + 1'b1;
            default:   addr = '0;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top. Runs the seven-step entry on a request,
// lets a pending NMI take over the vector read, and reports completion.
// Assumes a synchronous memory whose read data is valid in the addressed
// cycle, and an externally held NMI pending flag cleared by nmi_clear.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [2*DATA_W-1:0] IRQ_VEC    = 16'hFFFE,
    parameter int                  BRK_BIT    = 4,
    parameter int                  IDIS_BIT   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_req,
    input  logic                  nmi_pending,
    input  logic [2*DATA_W-1:0]   pc_in,
    input  logic [DATA_W-1:0]     sp_in,
    input  logic [DATA_W-1:0]     p_in,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  nmi_clear,
    output logic [2*DATA_W-1:0]   pc_out,
    output logic [DATA_W-1:0]     sp_out,
    output logic [DATA_W-1:0]     p_out,
    output logic                  busy,
    output logic                  done
);

    step_t state;
    logic  use_nmi;

    irq_step_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .nmi_pending (nmi_pending),
        .state_o     (state),
        .use_nmi_o   (use_nmi),
        .nmi_clear_o (nmi_clear)
    );

    irq_ctx_regs #(
        .DATA_W   (DATA_W),
        .IDIS_BIT (IDIS_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .irq_req (irq_req),
        .pc_in   (pc_in),
        .sp_in   (sp_in),
        .p_in    (p_in),
        .rdata   (mem_rdata),
        .pc_o    (pc_out),
        .sp_o    (sp_out),
        .p_o     (p_out)
    );

    irq_bus_drive #(
        .DATA_W     (DATA_W),
        .STACK_PAGE (STACK_PAGE),
        .NMI_VEC    (NMI_VEC),
        .IRQ_VEC    (IRQ_VEC),
        .BRK_BIT    (BRK_BIT)
    ) u_bus (
        .state   (state),
        .use_nmi (use_nmi),
        .pc      (pc_out),
        .sp      (sp_out),
        .p       (p_out),
        .addr    (mem_addr),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .wdata   (mem_wdata)
    );

    // Status outputs derived from the step.
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Port-level checker for the interrupt entry sequencer, bound to the top.
module irq_entry_seq_chk #(
    parameter int                  DATA_W     = 8,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] NMI_VEC    = 16'hFFFA,
    parameter int                  BRK_BIT    = 4,
    parameter int                  IDIS_BIT   = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_req,
    input logic [2*DATA_W-1:0]   mem_addr,
    input logic                  mem_rd,
    input logic                  mem_wr,
    input logic [DATA_W-1:0]     mem_wdata,
    input logic                  nmi_clear,
    input logic [DATA_W-1:0]     sp_out,
    input logic [DATA_W-1:0]     p_out,
    input logic                  busy,
    input logic                  done
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10

    AST_WR_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[2*DATA_W-1:DATA_W] == STACK_PAGE)); // R3

    AST_SP_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_out == $past(sp_out) - 1'b1)); // R4

    AST_STATUS_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr) && $past(mem_wr, 2)) |-> !mem_wdata[BRK_BIT]); // R4

    AST_IDIS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> p_out[IDIS_BIT]); // R5

    AST_CLEAR_WITH_NMI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clear |-> (mem_rd && mem_addr == NMI_VEC)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_VEC_HI: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd && mem_addr[0])); // R9

    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(irq_req)); // R2

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE),
    .NMI_VEC    (NMI_VEC),
    .BRK_BIT    (BRK_BIT),
    .IDIS_BIT   (IDIS_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .nmi_clear (nmi_clear),
    .sp_out    (sp_out),
    .p_out     (p_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        nmi_pend = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  p_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic        nmi_clear;
    logic [15:0] pc_out;
    logic [7:0]  sp_out, p_out;
    logic        busy, done;
    logic [7:0]  seed = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    // Memory model: data is a function of the address and a run seed.
    function automatic logic [7:0] memf(input logic [15:0] a, input logic [7:0] s);
        return a[7:0] ^ a[15:8] ^ s;
    endfunction
    assign mem_rdata = mem_rd ? memf(mem_addr, seed) : 8'h00;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_pending(nmi_pend),
        .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .nmi_clear(nmi_clear), .pc_out(pc_out),
        .sp_out(sp_out), .p_out(p_out), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One entry sequence; nmi_at: 0 = pending before start, k = set in cycle k.
    task automatic run_seq(input logic [15:0] pc, input logic [7:0] sp,
                           input logic [7:0] p, input logic [7:0] s,
                           input int nmi_at, input bit hold);
        logic        hij;
        logic [15:0] vlo;
        int          nwr;
        hij = (nmi_at <= 5);
        vlo = hij ? 16'hFFFA : 16'hFFFE;
        nwr = 0;
        seed = s; pc_in = pc; sp_in = sp; p_in = p;
        nmi_pend = (nmi_at == 0);
        irq_req = 1'b1;
        @(negedge clk);
        for (int c = 1; c <= 8; c++) begin
            chk("R9", "busy", busy, 1);
            chk("R10", "rd&wr", mem_rd & mem_wr, 0);
            if (mem_wr) nwr++;
            chk("R8", "nmi_clear", nmi_clear, (c == 6) && hij);
            if (c < 8) chk("R9", "done early", done, 0);
            case (c)
                1, 2: begin
                    chk("R2", "dummy rd", {mem_rd, mem_wr}, 2'b10);
                    chk("R2", "dummy addr", mem_addr, pc);
                end
                3: begin
                    chk("R3", "push hi addr", mem_addr, {8'h01, sp});
                    chk("R3", "push hi data", mem_wdata, pc[15:8]);
                end
                4: begin
                    chk("R3", "push lo addr", mem_addr, {8'h01, 8'(sp - 8'd1)});
                    chk("R3", "push lo data", mem_wdata, pc[7:0]);
                end
                5: begin
                    chk("R4", "push st addr", mem_addr, {8'h01, 8'(sp - 8'd2)});
                    chk("R4", "push st data", mem_wdata, p & 8'hEF);
                end
                6: begin
                    chk(hij ? "R7" : "R6", "vec lo addr", {mem_rd, mem_addr}, {1'b1, vlo});
                end
                7: begin
                    chk(hij ? "R7" : "R6", "vec hi addr", {mem_rd, mem_addr}, {1'b1, vlo + 16'd1});
                end
                default: begin
                    chk("R9", "done", done, 1);
                    chk(hij ? "R7" : "R6", "pc_out", pc_out,
                        {memf(vlo + 16'd1, s), memf(vlo, s)});
                    chk("R4", "sp_out", sp_out, 8'(sp - 8'd3));
                    chk("R5", "p_out", p_out, p | 8'h04);
                    chk("R10", "strobes at done", {mem_rd, mem_wr}, 2'b00);
                end
            endcase
            if (c == nmi_at) nmi_pend = 1'b1;
            if (c == 6 && nmi_clear) nmi_pend = 1'b0;
            if (!hold && c == 1) irq_req = 1'b0;
            if (c == 8) irq_req = 1'b0;
            @(negedge clk);
        end
        chk("R10", "write count", nwr, 3);
        chk("R10", "idle after held req", {busy, mem_rd, mem_wr}, 3'b000);
        chk("R8", "late nmi kept", nmi_pend, (nmi_at >= 1 && nmi_at <= 7 && !hij) ? 1 : 0);
        nmi_pend = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] pcs [4] = '{16'h0000, 16'h1234, 16'hFFFF, 16'h80FF};
        logic [7:0]  sps [5] = '{8'h00, 8'h01, 8'h02, 8'hFF, 8'h80};
        logic [7:0]  pss [4] = '{8'h00, 8'hFF, 8'h10, 8'h24};
        int          nats [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 99};
        int          run = 0;
        repeat (4) @(negedge clk);
        // R1: reset state while held in reset and after release
        chk("R1", "busy/done", {busy, done}, 2'b00);
        chk("R1", "strobes", {mem_rd, mem_wr, nmi_clear}, 3'b000);
        chk("R1", "regs", {pc_out, sp_out, p_out}, 32'h0);
        rst_n = 1'b1;
        nmi_pend = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle with nmi only", {busy, mem_rd, mem_wr, nmi_clear}, 4'b0000);
        nmi_pend = 1'b0;
        foreach (pcs[i]) foreach (sps[j]) foreach (pss[k]) foreach (nats[m]) begin
            run_seq(pcs[i], sps[j], pss[k], 8'(run * 37), nats[m], run[0]);
            run++;
        end
        finish_run();
    end

endmodule